// File: doc/BRIEF.md
# Cascadable Serial Converter Input Register

This block is the digital front end of a 12-bit voltage-output converter. A host sends each code over three wires: a serial clock, a data line and one combined select/load line. While select/load is low, every rising serial clock shifts one data bit into a 12-bit shift register, most significant bit first. When select/load rises, the shifted word is copied into the parallel code register that drives the converter. While select/load is high, serial clocks are ignored.

The last stage of the shift register is driven onto a serial output. Several blocks can therefore be chained: one block's serial output feeds the next block's data input, and all blocks share the clock and select/load lines. The host shifts 12 bits per device, sending the data for the farthest device first. One rise of select/load then updates every device in the same cycle.

The block runs on a free-running system clock. The serial clock, data and select/load inputs pass through two-flop synchronisers, and their edges are detected in the system-clock domain. An active-low clear input zeroes both registers at once, without waiting for a clock edge. A synchronous active-low system reset, used as the power-on reset, does the same.

Top module: `dac_serial_in`

## Requirements
- R1: While rst_n is low, and at the first clock after it is released, dac_code is 0 and sdo is 0.
- R2: While cs_ld is low, each rising edge of sclk shifts sdi into bit 0 of the 12-bit shift register, and the existing bits move one place toward bit 11. Words are sent B11 first.
- R3: While cs_ld is high, sclk edges leave the shift register unchanged. Neither sdo nor the word that the next load transfers is affected.
- R4: dac_code changes only on a rising edge of cs_ld, or through clear or reset. On a rise of cs_ld it takes the shift register contents. After a 12-bit frame it equals the word sent, with bit 11 sent first.
- R5: sdo is bit 11 of the shift register. Before each rising sclk of a frame, sdo shows the next bit of the previously loaded word, B11 first.
- R6: clr_n low zeroes dac_code, the shift register and sdo at once, without waiting for a clock edge. If cs_ld is raised after the clear is released and no bits have been shifted, 0 is loaded.
- R7: A frame of any length loads the last 12 bits shifted. A 15-bit frame loads its low 12 bits. A 5-bit frame loads {previous word[6:0], the five new bits}.
- R8: In two chained blocks (u0.sdo driving u1.sdi), a 24-bit frame leaves the first 12 bits sent in the far block and the last 12 bits sent in the near block. Both blocks load on the same cs_ld rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| clr_n | input | 1 | Asynchronous active-low clear of both registers |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| cs_ld | input | 1 | Select (low) and load (rising edge) |
| sdo | output | 1 | Last shift stage, for chaining |
| dac_code | output | 12 | Parallel code for the converter |

## Verification
The bound assertions check these properties on every system clock:
- each accepted strobe is a one-place shift that takes in the synchronised data bit;
- the shift register holds when no strobe occurs;
- the code register changes only on a load, which copies the shift register;
- clear holds both registers at zero;
- both registers are at zero when reset is released.

Some behaviour is visible only in the bench's scenarios:
- the end-to-end MSB-first ordering through the synchronisers;
- the previous word leaving on sdo;
- serial clocks ignored while deselected;
- the clear taking effect between clock edges;
- frames of the wrong length;
- a two-device chain.

// File: rtl/dac_in_pkg.sv
// Shared constants and types for the serial converter input register.
// Assumes a 12-bit converter and two-flop synchronisation by default.
package dac_in_pkg;
    localparam int CODE_W      = 12;
    localparam int SYNC_STAGES = 2;

    // Synchronised serial inputs, packed in a fixed order
    typedef struct packed {
        logic sclk;
        logic sdi;
        logic cs;
    } ser_in_t;

    // Idle levels of the serial inputs: clock low, data low, select high
    localparam ser_in_t SER_IDLE = '{sclk: 1'b0, sdi: 1'b0, cs: 1'b1};
endpackage

// File: rtl/dac_sync.sv
// Multi-bit level synchroniser: N independent chains of STAGES flops.
// Assumes each bit is a slow level, so the bits need not stay coherent.
// A synchronous active-low reset loads RST_VAL into every stage.
module dac_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] stg;

    // Move each input through its chain of flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_edge.sv
// Rising-edge detector for N synchronised levels, one detector per bit.
// Assumes inputs are already in the clk domain.
// RST_VAL should match the idle level of each input, so that reset release
// produces no false edge.
module dac_edge #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev;

        // Remember the last level of this bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev <= RST_VAL[g];
            else        prev <= lvl[g];
        end

        assign rise[g] = lvl[g] & ~prev;
    end
endmodule

// File: rtl/dac_shift_reg.sv
// W-bit MSB-first serial-in shift register with the last stage as serial out.
// Assumes shift_en is a single-cycle strobe.
// Clears asynchronously on clr_n, and synchronously on reset or clr_hold.
module dac_shift_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         clr_hold,
    input  logic         shift_en,
    input  logic         sdi,
    output logic [W-1:0] q,
    output logic         sdo
);
    // Shift one bit in at bit 0 per strobe; clear overrides shifting
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)                 q <= '0;
        else if (!rst_n || clr_hold) q <= '0;
        else if (shift_en)          q <= {q[W-2:0], sdi};
    end

    assign sdo = q[W-1];
endmodule

// File: rtl/dac_code_reg.sv
// W-bit parallel code register, loaded from the shift register on a strobe.
// Clears asynchronously on clr_n, and synchronously on reset or clr_hold.
module dac_code_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         clr_hold,
    input  logic         load_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Take the shifted word on a load strobe; clear overrides loading
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)                 q <= '0;
        else if (!rst_n || clr_hold) q <= '0;
        else if (load_en)           q <= d;
    end
endmodule

// File: rtl/dac_serial_in.sv
// Top of the cascadable serial converter input register.
// - Synchronises sclk, sdi and cs_ld.
// - Shifts on each rising sclk while cs_ld is low.
// - Loads the code register on a rising cs_ld.
// Assumes the host keeps each serial phase longer than the synchroniser
// latency, and lowers cs_ld only while sclk is low.
// clr_n clears at once. Its release is retimed, so the registers leave clear
// synchronously.
module dac_serial_in #(
    parameter int CODE_W      = dac_in_pkg::CODE_W,
    parameter int SYNC_STAGES = dac_in_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_ld,
    output logic              sdo,
    output logic [CODE_W-1:0] dac_code
);
    import dac_in_pkg::*;

    localparam int SER_W = $bits(ser_in_t);

    ser_in_t           raw_in;
    ser_in_t           syn_in;
    logic              sdi_s;
    logic [1:0]        rise;
    logic              shift_en;
    logic              load_en;
    logic [SYNC_STAGES-1:0] clr_pipe;
    logic              clr_hold;
    logic [CODE_W-1:0] sh_q;

    assign raw_in = '{sclk: sclk, sdi: sdi, cs: cs_ld};

    dac_sync #(
        .N       (SER_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SER_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    // Clear release retimer: drops at once, rises after SYNC_STAGES clocks
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      clr_pipe <= '0;
        else if (!rst_n) clr_pipe <= '0;
        else             clr_pipe <= {clr_pipe[SYNC_STAGES-2:0], 1'b1};
    end

    assign clr_hold = ~clr_pipe[SYNC_STAGES-1];

    dac_edge #(
        .N       (2),
        .RST_VAL ({SER_IDLE.sclk, SER_IDLE.cs})
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({syn_in.sclk, syn_in.cs}),
        .rise  (rise)
    );

    assign sdi_s    = syn_in.sdi;
    assign shift_en = rise[1] & ~syn_in.cs;
    assign load_en  = rise[0];

    dac_shift_reg #(.W(CODE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .clr_hold (clr_hold),
        .shift_en (shift_en),
        .sdi      (sdi_s),
        .q        (sh_q),
        .sdo      (sdo)
    );

    dac_code_reg #(.W(CODE_W)) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .clr_hold (clr_hold),
        .load_en  (load_en),
        .d        (sh_q),
        .q        (dac_code)
    );
endmodule

// File: rtl/dac_serial_in_chk.sv
// Assertion checker for dac_serial_in, attached to it by bind.
// It watches the strobes and both registers.
module dac_serial_in_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_n,
    input logic         clr_hold,
    input logic         shift_en,
    input logic         load_en,
    input logic         sdi_s,
    input logic [W-1:0] shreg,
    input logic [W-1:0] dac_code,
    input logic         sdo
);
    // R1
    rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == '0 && sdo == 1'b0));

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (dac_code == '0 && shreg == '0));

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr_hold) |=>
            (!clr_n || shreg == {$past(shreg[W-2:0]), $past(sdi_s)}));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clr_hold) |=> (!clr_n || clr_hold || $stable(shreg)));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !clr_hold) |=> (!clr_n || dac_code == $past(shreg)));

    // R4
    code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !clr_hold) |=> (!clr_n || clr_hold || $stable(dac_code)));
endmodule

bind dac_serial_in dac_serial_in_chk #(.W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .clr_hold (clr_hold),
    .shift_en (shift_en),
    .load_en  (load_en),
    .sdi_s    (sdi_s),
    .shreg    (sh_q),
    .dac_code (dac_code),
    .sdo      (sdo)
);

// File: tb/sim_dac_serial_in.sv
`timescale 1ns/1ps
// Bench for dac_serial_in: a code sweep, deselected clocks, clear, frames of
// the wrong length, and a two-device chain.
module sim_dac_serial_in;
    logic        clk = 1'b0;
    logic        rst_n, clr_n, sclk, sdi, cs_ld;
    logic        sdo0, sdo1;
    logic [11:0] code0, code1;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    dac_serial_in u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sclk(sclk), .sdi(sdi),
        .cs_ld(cs_ld), .sdo(sdo0), .dac_code(code0)
    );

    dac_serial_in u1 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sclk(sclk), .sdi(sdo0),
        .cs_ld(cs_ld), .sdo(sdo1), .dac_code(code1)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One serial bit: set data, record sdo before the rise, then pulse sclk
    task automatic clk_bit(input bit b, output bit seen);
        sdi = b;
        tick(4);
        seen = sdo0;
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
    endtask

    task automatic frame_begin();
        cs_ld = 1'b0;
        tick(4);
    endtask

    task automatic frame_end();
        tick(2);
        cs_ld = 1'b1;
        tick(6);
    endtask

    // Send a 12-bit word; check that sdo shows prev MSB first and that the load lands
    task automatic send_word(input logic [11:0] w, input logic [11:0] prev);
        bit s;
        frame_begin();
        for (int i = 11; i >= 0; i--) begin
            clk_bit(w[i], s);
            chk("R5 sdo shows previous word", {31'd0, s}, {31'd0, prev[i]});
            chk("R4 code stable while shifting", {20'd0, code0}, {20'd0, prev});
        end
        frame_end();
        chk("R2 R4 loaded code", {20'd0, code0}, {20'd0, w});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] prev;
        logic [14:0] lng;
        logic [4:0]  shrt;
        logic [11:0] w0, w1;
        bit          s;

        rst_n = 1'b0; clr_n = 1'b1; sclk = 1'b0; sdi = 1'b0; cs_ld = 1'b1;
        tick(5);
        chk("R1 code in reset", {20'd0, code0}, 32'd0);
        chk("R1 sdo in reset", {31'd0, sdo0}, 32'd0);
        rst_n = 1'b1;
        tick(5);
        chk("R1 code after reset", {20'd0, code0}, 32'd0);

        // R2 R4 R5: sweep of codes, then walking ones and all ones
        prev = 12'd0;
        for (int c = 0; c < 4096; c += 41) begin
            send_word(c[11:0], prev);
            prev = c[11:0];
        end
        for (int b = 0; b < 12; b++) begin
            send_word(12'd1 << b, prev);
            prev = 12'd1 << b;
        end
        send_word(12'hFFF, prev);
        send_word(12'hA5C, 12'hFFF);
        prev = 12'hA5C;

        // R3: clocks while deselected are ignored
        sdi = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
        end
        tick(4);
        chk("R3 sdo unchanged", {31'd0, sdo0}, {31'd0, prev[11]});
        chk("R3 code unchanged", {20'd0, code0}, {20'd0, prev});
        frame_begin();
        frame_end();
        chk("R3 empty frame reloads held word", {20'd0, code0}, {20'd0, prev});

        // R7: long frame keeps the last 12 bits
        lng = 15'h5A3C;
        frame_begin();
        for (int i = 14; i >= 0; i--) clk_bit(lng[i], s);
        frame_end();
        chk("R7 15-bit frame", {20'd0, code0}, {20'd0, lng[11:0]});
        prev = lng[11:0];

        // R7: short frame merges with the previous word
        shrt = 5'b10110;
        frame_begin();
        for (int i = 4; i >= 0; i--) clk_bit(shrt[i], s);
        frame_end();
        chk("R7 5-bit frame", {20'd0, code0}, {20'd0, prev[6:0], shrt});

        // R6: clear in the middle of a frame
        send_word(12'h9C5, {prev[6:0], shrt});
        frame_begin();
        for (int i = 0; i < 5; i++) clk_bit(i[0], s);
        clr_n = 1'b0;
        #1;
        chk("R6 code cleared before clock edge", {20'd0, code0}, 32'd0);
        chk("R6 sdo cleared", {31'd0, sdo0}, 32'd0);
        tick(3);
        clr_n = 1'b1;
        tick(4);
        frame_end();
        chk("R6 shift register cleared", {20'd0, code0}, 32'd0);

        // R8: two-device chain, far word first
        for (int k = 0; k < 3; k++) begin
            w1 = 12'h3E7 ^ (12'h111 * k[11:0]);
            w0 = 12'hC18 + (12'h0A3 * k[11:0]);
            frame_begin();
            for (int i = 11; i >= 0; i--) clk_bit(w1[i], s);
            for (int i = 11; i >= 0; i--) clk_bit(w0[i], s);
            frame_end();
            chk("R8 near device", {20'd0, code0}, {20'd0, w0});
            chk("R8 far device", {20'd0, code1}, {20'd0, w1});
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule